// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block resolves a single operand of a 16-bit instruction. It takes a 3-bit addressing mode and a 3-bit register number. It reads from and updates an eight-entry register file, in which the highest entry acts as the program counter. It then reports where the operand lives and what the operand holds. A register operand is reported as a register number. A memory operand is reported as its final effective address together with the data read from that address. Index words, immediate words, absolute words and pointer words are all fetched through a simple request/acknowledge read port. A byte/word flag sets the width of the operand read and the size of the automatic steps.

A caller pulses `start` with mode, register and width applied. The sequencer walks through its states and pulses `done` for one cycle while `is_reg`, `loc` and `value` are valid. Any register update (post-increment, pre-decrement, or the program counter stepping past an extra word) is written at the clock edge that ends the `done` cycle. The register file can be loaded and inspected through a side port, and that port accepts writes only while the sequencer is idle.

The states are `ST_IDLE`, `ST_INDEX`, `ST_POINTER`, `ST_OPERAND` and `ST_DONE`. The transitions are:
- IDLE to DONE for mode 0.
- IDLE to OPERAND for modes 1, 2 and 4.
- IDLE to POINTER for modes 3 and 5.
- IDLE to INDEX for modes 6 and 7.
- INDEX to OPERAND (mode 6) or to POINTER (mode 7) on acknowledge.
- POINTER to OPERAND on acknowledge.
- OPERAND to DONE on acknowledge.
- DONE to IDLE always.

Top module: `amode_seq`

## Requirements
- R1: Mode 0 pulses `done` one cycle after `start`, with `is_reg`=1, `loc` equal to the register number and `value` equal to the register contents. It issues no memory read.
- R2: Mode 1 reads the operand at the address held in the register. `loc` is that address and the register is unchanged.
- R3: Mode 2 reads the operand at the register's address, then adds the step (1 for byte, 2 for word) to the register. With register 7 this yields an immediate operand at the old program counter, and the program counter advances by 2.
- R4: Mode 3 reads a pointer word at the register's address and then reads the operand at that pointer. The register advances by 2 even for byte operations. With register 7 this is an absolute address.
- R5: Mode 4 first subtracts the step (1 byte, 2 word) from the register and uses the new value as the operand address.
- R6: Mode 5 subtracts 2 from the register, reads a pointer at the new value, and reads the operand at that pointer.
- R7: Mode 6 reads an index word at the program counter, advances the program counter by 2, and uses index plus register as the address. With register 7 the base is the already-advanced program counter.
- R8: Mode 7 forms the same address as mode 6, reads a pointer word there, and reads the operand at that pointer.
- R9: In byte mode, the automatic steps of modes 2 and 4 are 2 when the register is 6 or 7.
- R10: `mem_req` with `mem_addr` stays stable until `mem_ack`. Index and pointer reads use `mem_byte`=0. Only the final operand read carries `mem_byte` equal to the byte flag.
- R11: After reset all registers read 0 and `done` and `mem_req` are low. A register update becomes readable in the cycle after `done`, and `done` lasts one cycle.
- R12: A side-port write (`ext_we`) is ignored while a resolution is in progress.
- R13: A byte operand's value is the byte in bits 7:0, zero-extended; for a memory read the port returns the addressed byte in `mem_rdata[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch resolution (sampled in idle) |
| mode | input | 3 | Addressing mode |
| rsel | input | 3 | Register number |
| byte_op | input | 1 | 1 = byte operand, 0 = word |
| done | output | 1 | One-cycle completion pulse |
| is_reg | output | 1 | Operand is a register |
| loc | output | 16 | Register number or effective address |
| value | output | 16 | Operand value |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_byte | output | 1 | Read is a byte read |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 16 | Read data |
| ext_we | input | 1 | Side-port register write |
| ext_widx | input | 3 | Side-port write index |
| ext_wdata | input | 16 | Side-port write data |
| ext_ridx | input | 3 | Side-port read index |
| ext_rdata | output | 16 | Side-port read data |

## Verification
Every mode is driven with an ordinary register and with register 7. This separates the generic behaviour from the immediate, absolute and relative meanings, and shows whether the relative base is the stepped program counter. Modes 2 and 4 are each run in word and byte form with a low register and with the stack register, which isolates the 1-versus-2 step choice. Modes 3 and 5 are also run in byte form to show that their step stays at 2. The memory model adds wait states and logs each read's address and width, so the read order, the word/byte flag per read and the stability of held requests are compared for every case. A side-port write during a busy resolution shows whether the register file is guarded.

// File: rtl/amode_pkg.sv
package amode_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INDEX,
        ST_POINTER,
        ST_OPERAND,
        ST_DONE
    } seq_state_t;

    localparam int BYTE_BITS = 8;
    localparam int WIDE_STEP_FROM = 6;
endpackage

// File: rtl/amode_regfile.sv
module amode_regfile #(
    parameter int W = 16,
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic [IW-1:0] rc_idx,
    output logic [W-1:0]  rc_data
);
    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && widx == IW'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];
    assign rc_data = regs[rc_idx];
endmodule

// File: rtl/amode_step.sv
module amode_step #(
    parameter int W = 16,
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG)
) (
    input  logic [W-1:0]  base,
    input  logic          byte_op,
    input  logic          force_word,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  inc,
    output logic [W-1:0]  dec
);
    import amode_pkg::*;

    logic [W-1:0] step;

    always_comb begin
        if (byte_op && !force_word && ridx < IW'(WIDE_STEP_FROM)) begin
            step = W'(1);
        end else begin
            step = W'(2);
        end
        inc = base + step;
        dec = base - step;
    end
endmodule

// File: rtl/amode_seq.sv
module amode_seq #(
    parameter int W = 16,
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [IW-1:0] rsel,
    input  logic          byte_op,
    output logic          done,
    output logic          is_reg,
    output logic [W-1:0]  loc,
    output logic [W-1:0]  value,
    output logic          mem_req,
    output logic [W-1:0]  mem_addr,
    output logic          mem_byte,
    input  logic          mem_ack,
    input  logic [W-1:0]  mem_rdata,
    input  logic          ext_we,
    input  logic [IW-1:0] ext_widx,
    input  logic [W-1:0]  ext_wdata,
    input  logic [IW-1:0] ext_ridx,
    output logic [W-1:0]  ext_rdata
);
    import amode_pkg::*;

    localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

    seq_state_t state, state_nx;

    logic [2:0]    mode_q;
    logic [IW-1:0] reg_q;
    logic          byte_q;
    logic [W-1:0]  addr_q;
    logic          is_reg_q;
    logic [W-1:0]  loc_q;
    logic [W-1:0]  value_q;
    logic          upd_en_q;
    logic [IW-1:0] upd_idx_q;
    logic [W-1:0]  upd_val_q;

    logic [IW-1:0] sel_idx;
    logic [W-1:0]  rv;
    logic [W-1:0]  pcv;
    logic [W-1:0]  step_inc;
    logic [W-1:0]  step_dec;
    logic          rf_we;
    logic [IW-1:0] rf_widx;
    logic [W-1:0]  rf_wdata;
    logic          busy;

    function automatic logic [W-1:0] low_byte(input logic [W-1:0] x);
        return {{(W-BYTE_BITS){1'b0}}, x[BYTE_BITS-1:0]};
    endfunction

    assign sel_idx = (state == ST_IDLE) ? rsel : reg_q;
    assign busy    = (state != ST_IDLE);

    always_comb begin
        if (state == ST_DONE && upd_en_q) begin
            rf_we    = 1'b1;
            rf_widx  = upd_idx_q;
            rf_wdata = upd_val_q;
        end else begin
            rf_we    = ext_we && !busy;
            rf_widx  = ext_widx;
            rf_wdata = ext_wdata;
        end
    end

    amode_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .widx    (rf_widx),
        .wdata   (rf_wdata),
        .ra_idx  (sel_idx),
        .ra_data (rv),
        .rb_idx  (PC_IDX),
        .rb_data (pcv),
        .rc_idx  (ext_ridx),
        .rc_data (ext_rdata)
    );

    amode_step #(.W(W), .NREG(NREG)) u_step (
        .base       (rv),
        .byte_op    (byte_op),
        .force_word (mode == 3'd3 || mode == 3'd5),
        .ridx       (rsel),
        .inc        (step_inc),
        .dec        (step_dec)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    unique case (mode)
                        3'd0:             state_nx = ST_DONE;
                        3'd1, 3'd2, 3'd4: state_nx = ST_OPERAND;
                        3'd3, 3'd5:       state_nx = ST_POINTER;
                        default:          state_nx = ST_INDEX;
                    endcase
                end
            end
            ST_INDEX:   if (mem_ack) state_nx = (mode_q == 3'd6) ? ST_OPERAND : ST_POINTER;
            ST_POINTER: if (mem_ack) state_nx = ST_OPERAND;
            ST_OPERAND: if (mem_ack) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            reg_q     <= '0;
            byte_q    <= 1'b0;
            addr_q    <= '0;
            is_reg_q  <= 1'b0;
            loc_q     <= '0;
            value_q   <= '0;
            upd_en_q  <= 1'b0;
            upd_idx_q <= '0;
            upd_val_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q   <= mode;
                        reg_q    <= rsel;
                        byte_q   <= byte_op;
                        is_reg_q <= (mode == 3'd0);
                        upd_en_q <= 1'b0;
                        unique case (mode)
                            3'd0: begin
                                loc_q   <= W'(rsel);
                                value_q <= byte_op ? low_byte(rv) : rv;
                            end
                            3'd1: addr_q <= rv;
                            3'd2, 3'd3: begin
                                addr_q    <= rv;
                                upd_en_q  <= 1'b1;
                                upd_idx_q <= rsel;
                                upd_val_q <= step_inc;
                            end
                            3'd4, 3'd5: begin
                                addr_q    <= step_dec;
                                upd_en_q  <= 1'b1;
                                upd_idx_q <= rsel;
                                upd_val_q <= step_dec;
                            end
                            default: begin
                                addr_q    <= pcv;
                                upd_en_q  <= 1'b1;
                                upd_idx_q <= PC_IDX;
                                upd_val_q <= pcv + W'(2);
                            end
                        endcase
                    end
                end
                ST_INDEX: begin
                    if (mem_ack) begin
                        addr_q <= mem_rdata + ((reg_q == PC_IDX) ? upd_val_q : rv);
                    end
                end
                ST_POINTER: begin
                    if (mem_ack) addr_q <= mem_rdata;
                end
                ST_OPERAND: begin
                    if (mem_ack) begin
                        loc_q   <= addr_q;
                        value_q <= byte_q ? low_byte(mem_rdata) : mem_rdata;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req  = (state == ST_INDEX) || (state == ST_POINTER) || (state == ST_OPERAND);
        mem_addr = addr_q;
        mem_byte = (state == ST_OPERAND) && byte_q;
        done     = (state == ST_DONE);
        is_reg   = is_reg_q;
        loc      = loc_q;
        value    = value_q;
    end

    // R10: held request keeps its address
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R10: index and pointer reads are word reads
    a_r10_word_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && state != ST_OPERAND |-> !mem_byte);

    // R1: register mode completes in one cycle without memory
    a_r1_reg_fast: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE && start && mode == 3'd0 |=> done && is_reg && !mem_req);

    // R11: done is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: side-port write while busy leaves the targeted register alone
    a_r12_busy_guard: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && ext_we && ext_widx == ext_ridx |=> $stable(ext_rdata) || done || $changed(ext_ridx));
endmodule

// File: tb/amode_seq_tb.sv
module amode_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  rsel = '0;
    logic        byte_op = 1'b0;
    logic        done, is_reg, mem_req, mem_byte;
    logic [15:0] loc, value, mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        ext_we = 1'b0;
    logic [2:0]  ext_widx = '0;
    logic [15:0] ext_wdata = '0;
    logic [2:0]  ext_ridx = '0;
    logic [15:0] ext_rdata;

    always #4 clk = ~clk;

    amode_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rsel(rsel),
        .byte_op(byte_op), .done(done), .is_reg(is_reg), .loc(loc), .value(value),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_byte(mem_byte),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ext_we(ext_we),
        .ext_widx(ext_widx), .ext_wdata(ext_wdata), .ext_ridx(ext_ridx),
        .ext_rdata(ext_rdata)
    );

    int nchk = 0;
    int nfail = 0;
    logic [15:0] mem [0:255];

    // memory model: two wait cycles, logs each accepted read
    int          wcnt = 0;
    int          nrd = 0;
    int          hold_err = 0;
    logic [15:0] hold_addr = '0;
    logic [15:0] la [0:7];
    logic        lb [0:7];

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt = 0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt > 0 && mem_addr !== hold_addr) hold_err++;
            hold_addr = mem_addr;
            if (wcnt == 2) begin
                wcnt = 0;
                mem_ack <= 1'b1;
                if (mem_byte)
                    mem_rdata <= mem_addr[0] ? {8'h00, mem[mem_addr[8:1]][15:8]}
                                             : {8'h00, mem[mem_addr[8:1]][7:0]};
                else
                    mem_rdata <= mem[mem_addr[8:1]];
                if (nrd < 8) begin
                    la[nrd] = mem_addr;
                    lb[nrd] = mem_byte;
                end
                nrd++;
            end else begin
                wcnt++;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    logic        r_isreg;
    logic [15:0] r_loc, r_val;
    int          r_lat;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        mem[a[8:1]] = d;
    endtask

    task automatic set_reg(input logic [2:0] i, input logic [15:0] d);
        @(negedge clk);
        ext_we = 1'b1; ext_widx = i; ext_wdata = d;
        @(negedge clk);
        ext_we = 1'b0;
    endtask

    task automatic get_reg(input logic [2:0] i, output logic [15:0] d);
        ext_ridx = i;
        #1;
        d = ext_rdata;
    endtask

    task automatic kick(input logic [2:0] m, input logic [2:0] r, input logic b);
        @(negedge clk);
        nrd = 0;
        mode = m; rsel = r; byte_op = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_lat = 1;
    endtask

    task automatic finish_run();
        while (!done && r_lat < 100) begin
            @(negedge clk);
            r_lat++;
        end
        r_isreg = is_reg; r_loc = loc; r_val = value;
        @(negedge clk);
    endtask

    task automatic run(input logic [2:0] m, input logic [2:0] r, input logic b);
        kick(m, r, b);
        finish_run();
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R11", "done after reset", done, 0);
        chk("R11", "mem_req after reset", mem_req, 0);
        get_reg(7, d);
        chk("R11", "pc after reset", d, 16'h0000);
    endtask

    task automatic t_mode0();
        set_reg(3, 16'h1234);
        run(0, 3, 0);
        chk("R1", "latency", r_lat, 1);
        chk("R1", "is_reg", r_isreg, 1);
        chk("R1", "loc", r_loc, 3);
        chk("R1", "value", r_val, 16'h1234);
        chk("R1", "no reads", nrd, 0);
        run(0, 3, 1);
        chk("R13", "byte reg value", r_val, 16'h0034);
    endtask

    task automatic t_mode1();
        logic [15:0] d;
        set_reg(3, 16'h0100);
        poke(16'h0100, 16'hABCD);
        run(1, 3, 0);
        chk("R2", "is_reg", r_isreg, 0);
        chk("R2", "loc", r_loc, 16'h0100);
        chk("R2", "value", r_val, 16'hABCD);
        get_reg(3, d);
        chk("R2", "reg unchanged", d, 16'h0100);
    endtask

    task automatic t_mode2();
        logic [15:0] d;
        set_reg(3, 16'h0100);
        run(2, 3, 0);
        get_reg(3, d);
        chk("R3", "word value", r_val, 16'hABCD);
        chk("R3", "word post-inc", d, 16'h0102);
        set_reg(3, 16'h0101);
        run(2, 3, 1);
        get_reg(3, d);
        chk("R13", "odd byte value", r_val, 16'h00AB);
        chk("R10", "operand byte flag", lb[0], 1);
        chk("R3", "byte post-inc", d, 16'h0102);
        set_reg(7, 16'h0040);
        poke(16'h0040, 16'h5555);
        run(2, 7, 0);
        get_reg(7, d);
        chk("R3", "immediate loc", r_loc, 16'h0040);
        chk("R3", "immediate value", r_val, 16'h5555);
        chk("R3", "pc after immediate", d, 16'h0042);
    endtask

    task automatic t_mode3();
        logic [15:0] d;
        set_reg(2, 16'h0110);
        poke(16'h0110, 16'h0120);
        poke(16'h0120, 16'h7777);
        run(3, 2, 0);
        get_reg(2, d);
        chk("R4", "loc", r_loc, 16'h0120);
        chk("R4", "value", r_val, 16'h7777);
        chk("R4", "reg +2", d, 16'h0112);
        chk("R10", "pointer read word", lb[0], 0);
        set_reg(2, 16'h0110);
        run(3, 2, 1);
        get_reg(2, d);
        chk("R4", "byte still +2", d, 16'h0112);
        chk("R13", "byte via pointer", r_val, 16'h0077);
        set_reg(7, 16'h0044);
        poke(16'h0044, 16'h0130);
        poke(16'h0130, 16'h4242);
        run(3, 7, 0);
        get_reg(7, d);
        chk("R4", "absolute loc", r_loc, 16'h0130);
        chk("R4", "absolute value", r_val, 16'h4242);
        chk("R4", "pc after absolute", d, 16'h0046);
    endtask

    task automatic t_mode4();
        logic [15:0] d;
        set_reg(4, 16'h0102);
        run(4, 4, 0);
        get_reg(4, d);
        chk("R5", "word loc", r_loc, 16'h0100);
        chk("R5", "word reg", d, 16'h0100);
        set_reg(4, 16'h0102);
        run(4, 4, 1);
        get_reg(4, d);
        chk("R5", "byte loc", r_loc, 16'h0101);
        chk("R5", "byte value", r_val, 16'h00AB);
        chk("R5", "byte reg", d, 16'h0101);
    endtask

    task automatic t_mode5();
        logic [15:0] d;
        set_reg(5, 16'h0112);
        run(5, 5, 1);
        get_reg(5, d);
        chk("R6", "reg -2 in byte mode", d, 16'h0110);
        chk("R6", "pointer addr", la[0], 16'h0110);
        chk("R6", "loc", r_loc, 16'h0120);
        chk("R6", "value", r_val, 16'h0077);
    endtask

    task automatic t_mode6();
        logic [15:0] d;
        set_reg(3, 16'h0100);
        set_reg(7, 16'h0050);
        poke(16'h0050, 16'h0006);
        poke(16'h0106, 16'h1111);
        run(6, 3, 0);
        chk("R7", "index fetch addr", la[0], 16'h0050);
        chk("R7", "loc", r_loc, 16'h0106);
        chk("R7", "value", r_val, 16'h1111);
        get_reg(7, d);
        chk("R7", "pc +2", d, 16'h0052);
        get_reg(3, d);
        chk("R7", "base reg unchanged", d, 16'h0100);
        set_reg(7, 16'h0060);
        poke(16'h0060, 16'h0020);
        poke(16'h0082, 16'h2222);
        run(6, 7, 0);
        chk("R7", "relative loc", r_loc, 16'h0082);
        chk("R7", "relative value", r_val, 16'h2222);
    endtask

    task automatic t_mode7();
        logic [15:0] d;
        set_reg(1, 16'h0100);
        set_reg(7, 16'h0070);
        poke(16'h0070, 16'h0010);
        run(7, 1, 1);
        chk("R8", "reads", nrd, 3);
        chk("R8", "pointer addr", la[1], 16'h0110);
        chk("R8", "loc", r_loc, 16'h0120);
        chk("R8", "value", r_val, 16'h0077);
        chk("R10", "index word", lb[0], 0);
        chk("R10", "pointer word", lb[1], 0);
        chk("R10", "operand byte", lb[2], 1);
        set_reg(7, 16'h0074);
        poke(16'h0074, 16'h000E);
        poke(16'h0084, 16'h0130);
        run(7, 7, 0);
        get_reg(7, d);
        chk("R8", "relative deferred loc", r_loc, 16'h0130);
        chk("R8", "relative deferred value", r_val, 16'h4242);
        chk("R8", "pc +2", d, 16'h0076);
    endtask

    task automatic t_wide_step();
        logic [15:0] d;
        set_reg(6, 16'h0080);
        run(2, 6, 1);
        get_reg(6, d);
        chk("R9", "sp byte post-inc", d, 16'h0082);
        run(4, 6, 1);
        get_reg(6, d);
        chk("R9", "sp byte pre-dec", d, 16'h0080);
        set_reg(7, 16'h0040);
        run(2, 7, 1);
        get_reg(7, d);
        chk("R9", "pc byte post-inc", d, 16'h0042);
    endtask

    task automatic t_busy_write();
        logic [15:0] d;
        set_reg(1, 16'h0100);
        set_reg(7, 16'h0070);
        kick(7, 1, 0);
        ext_we = 1'b1; ext_widx = 1; ext_wdata = 16'hDEAD;
        @(negedge clk);
        ext_we = 1'b0;
        r_lat++;
        finish_run();
        get_reg(1, d);
        chk("R12", "busy write ignored", d, 16'h0100);
        chk("R12", "result intact", r_val, 16'h7777);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_mode1();
        t_mode2();
        t_mode3();
        t_mode4();
        t_mode5();
        t_mode6();
        t_mode7();
        t_wide_step();
        t_busy_write();
        chk("R10", "held address stable", hold_err, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule